// File: doc/BRIEF.md
# DSP Condition Flag Unit

This block produces one condition bit for a DSP arithmetic stage that works on 40-bit signed values, where each value is a 32-bit main field with 8 extension (guard) bits stacked above it. Each cycle it adds or subtracts the two sources, presents the 40-bit result together with sign, zero and range-exceeded indications, and, when asked to, latches a single condition bit chosen by a 3-bit selector.

The selector picks between six conditions. The first is carry or borrow. The second and third are the result's sign and whether the result is zero. The fourth is overflow of the 32-bit main field, judged as if the extension bits did not exist. The last two are signed greater-than and signed greater-or-equal after a compare. The compare conditions correct the sign for results that leave the 40-bit range, so they always agree with a true signed comparison of the sources.

Top module: `cond_flag_unit`

## Requirements
- R1: `result` equals `srcA + srcB` modulo 2^40 when `opCode` is 00 (add), and `srcA - srcB` modulo 2^40 for opCode 01 (subtract), 10 (compare) or 11 (treated as subtract), in the same cycle.
- R2: `negative` is bit 39 of `result`, and `zero` is high exactly when all 40 result bits are 0, in the same cycle.
- R3: `overRange` is high exactly when the exact signed (41-bit) add or subtract result lies outside -2^39 .. 2^39-1.
- R4: With `condSel` 000 the flag takes the carry out of bit 39 for an add, or the unsigned borrow (srcA < srcB as unsigned values) for subtract and compare.
- R5: With `condSel` 001 the flag takes `negative`. With 010 it takes `zero`.
- R6: With `condSel` 011 the flag is set when result bits 39..31 are not all equal, i.e. the value does not fit in 32 signed bits, even when the 40-bit result is valid. 0xFF_FFFFFFFF + 0xFF_80000000 sets it. 0xFF_FFFFFFFF + 0xFF_80000001 clears it.
- R7: With `condSel` 100 the flag is NOT((negative XOR overRange) OR zero). For a compare this equals signed srcA > srcB for every operand pair.
- R8: With `condSel` 101 the flag is NOT(negative XOR overRange). For a compare this equals signed srcA >= srcB.
- R9: With `condSel` 110 or 111 the flag keeps its value even when `updEn` is high.
- R10: The flag changes only at a rising clock edge where `updEn` is high. The new value is visible after that edge.
- R11: Reset (`rstN` low) clears the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcA | input | 40 | Source 1 operand, two's complement |
| srcB | input | 40 | Source 2 operand, two's complement |
| opCode | input | 2 | 00 add, 01 subtract, 10 compare, 11 subtract |
| condSel | input | 3 | Condition select |
| updEn | input | 1 | Latch the selected condition at the next edge |
| result | output | 40 | Arithmetic result |
| flag | output | 1 | Registered condition bit |
| negative | output | 1 | Result bit 39 |
| zero | output | 1 | Result is all zeros |
| overRange | output | 1 | Signed 40-bit overflow of the operation |

## Verification
The result, sign, zero and range outputs are combinational, so they are checked one nanosecond after the inputs change at a falling edge, in the same cycle. The condition bit passes through one register, so its expected value is checked one nanosecond after the next rising edge, before the inputs change again. A bench model that holds its own copy of the flag makes the expected value cover the hold cases (enable low, reserved codes) as well as the update cases.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;
  localparam int MAIN_W  = 32;
  localparam int GUARD_W = 8;
  localparam int DATA_W  = MAIN_W + GUARD_W;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_ALT = 2'b11
  } opKind_e;

  typedef enum logic [2:0] {
    SEL_CARRY = 3'b000,
    SEL_NEG   = 3'b001,
    SEL_ZERO  = 3'b010,
    SEL_OVF   = 3'b011,
    SEL_GT    = 3'b100,
    SEL_GE    = 3'b101,
    SEL_RSV0  = 3'b110,
    SEL_RSV1  = 3'b111
  } condSel_e;

  localparam int N_COND = 6;
  localparam int P_CARRY = 0;
  localparam int P_NEG   = 1;
  localparam int P_ZERO  = 2;
  localparam int P_OVF   = 3;
  localparam int P_GT    = 4;
  localparam int P_GE    = 5;

  typedef struct packed {
    logic              load;
    logic [N_COND-1:0] pick;
  } ctlStrobe_t;
endpackage

// File: rtl/cond_control.sv
module cond_control
  import cond_flag_pkg::*;
(
  input  logic [2:0] condSel,
  input  logic       updEn,
  output ctlStrobe_t ctl
);
  always_comb begin
    ctl.pick = '0;
    unique case (condSel)
      SEL_CARRY: ctl.pick[P_CARRY] = 1'b1;
      SEL_NEG:   ctl.pick[P_NEG]   = 1'b1;
      SEL_ZERO:  ctl.pick[P_ZERO]  = 1'b1;
      SEL_OVF:   ctl.pick[P_OVF]   = 1'b1;
      SEL_GT:    ctl.pick[P_GT]    = 1'b1;
      SEL_GE:    ctl.pick[P_GE]    = 1'b1;
      default:   ctl.pick = '0;
    endcase
    ctl.load = updEn & (|ctl.pick);
  end
endmodule

// File: rtl/cond_datapath.sv
module cond_datapath
  import cond_flag_pkg::*;
#(
  parameter int MW = MAIN_W,
  parameter int GW = GUARD_W,
  localparam int W = MW + GW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [1:0]   opCode,
  input  ctlStrobe_t   ctl,
  output logic [W-1:0] result,
  output logic         flagQ,
  output logic         negative,
  output logic         zero,
  output logic         overRange
);
  logic         isAdd;
  logic [W-1:0] bEff;
  logic [W:0]   wide;
  logic         carryBit;
  logic         mainOvf;
  logic [N_COND-1:0] cand;
  logic         flagNext;

  assign isAdd = (opCode == OP_ADD);
  assign bEff  = isAdd ? srcB : ~srcB;
  assign wide  = {1'b0, srcA} + {1'b0, bEff} + {{W{1'b0}}, ~isAdd};

  assign result    = wide[W-1:0];
  assign negative  = result[W-1];
  assign zero      = (result == '0);
  assign carryBit  = isAdd ? wide[W] : ~wide[W];
  assign overRange = (srcA[W-1] == bEff[W-1]) && (result[W-1] != srcA[W-1]);
  assign mainOvf   = (result[W-1:MW-1] != {(GW+1){result[MW-1]}});

  always_comb begin
    cand          = '0;
    cand[P_CARRY] = carryBit;
    cand[P_NEG]   = negative;
    cand[P_ZERO]  = zero;
    cand[P_OVF]   = mainOvf;
    cand[P_GT]    = ~((negative ^ overRange) | zero);
    cand[P_GE]    = ~(negative ^ overRange);
  end

  assign flagNext = |(cand & ctl.pick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagQ <= 1'b0;
    else if (ctl.load) flagQ <= flagNext;
  end

  // R10: no load strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(flagQ));

  // R7: compare under greater-than matches a true signed compare
  a_r7_gt: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.pick[P_GT] && opCode == OP_CMP)
      |=> flagQ == $past($signed(srcA) > $signed(srcB)));

  // R8: compare under greater-or-equal matches a true signed compare
  a_r8_ge: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.pick[P_GE] && opCode == OP_CMP)
      |=> flagQ == $past($signed(srcA) >= $signed(srcB)));

  // R6: main-field overflow means the top nine bits are mixed
  a_r6_main_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.pick[P_OVF])
      |=> flagQ == $past(!(&result[W-1:MW-1]) && (|result[W-1:MW-1])));

  // R4: borrow for subtract/compare is an unsigned less-than
  a_r4_borrow: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.pick[P_CARRY] && !isAdd)
      |=> flagQ == $past(srcA < srcB));
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cond_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [1:0]        opCode,
  input  logic [2:0]        condSel,
  input  logic              updEn,
  output logic [DATA_W-1:0] result,
  output logic              flag,
  output logic              negative,
  output logic              zero,
  output logic              overRange
);
  ctlStrobe_t ctl;

  cond_control u_ctl (
    .condSel (condSel),
    .updEn   (updEn),
    .ctl     (ctl)
  );

  cond_datapath #(.MW(MAIN_W), .GW(GUARD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcA      (srcA),
    .srcB      (srcB),
    .opCode    (opCode),
    .ctl       (ctl),
    .result    (result),
    .flagQ     (flag),
    .negative  (negative),
    .zero      (zero),
    .overRange (overRange)
  );

  // R9: reserved selector codes never disturb the flag
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && condSel[2:1] == 2'b11) |=> $stable(flag));
endmodule

// File: tb/tb_cond_flag_unit.sv
`timescale 1ns/1ps
module tb_cond_flag_unit;
  localparam int W = 40;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] srcA = '0, srcB = '0;
  logic [1:0]   opCode = 2'b00;
  logic [2:0]   condSel = 3'b000;
  logic         updEn = 1'b0;
  logic [W-1:0] result;
  logic         flag, negative, zero, overRange;

  int nChecks = 0;
  int nFails  = 0;
  logic modelFlag = 1'b0;

  always #5 clk = ~clk;

  cond_flag_unit dut (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .opCode(opCode),
    .condSel(condSel), .updEn(updEn), .result(result), .flag(flag),
    .negative(negative), .zero(zero), .overRange(overRange)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h op=%0d sel=%0d en=%0b)",
               req, act, exp, srcA, srcB, opCode, condSel, updEn);
    end
  endtask

  task automatic applyVec(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [1:0] op, input logic [2:0] sel, input logic en);
    logic [W:0] sa, sb, ex;
    logic [W-1:0] expRes;
    logic expOvr, expCarry, expMain, expF, inRange;
    @(negedge clk);
    srcA = a; srcB = b; opCode = op; condSel = sel; updEn = en;
    sa = {a[W-1], a};
    sb = {b[W-1], b};
    ex = (op == 2'b00) ? sa + sb : sa - sb;
    expRes = ex[W-1:0];
    inRange = ($signed(ex) >= -(41'sd1 <<< 39)) && ($signed(ex) <= (41'sd1 <<< 39) - 41'sd1);
    expOvr = !inRange;
    expCarry = (op == 2'b00) ? ((({1'b0, a} + {1'b0, b}) >> W) != 0) : (a < b);
    expMain = !(($signed(expRes) >= -(40'sd1 <<< 31)) && ($signed(expRes) < (40'sd1 <<< 31)));
    #1;
    check("R1 result", result, expRes);
    check("R2 negative", {39'd0, negative}, {39'd0, expRes[W-1]});
    check("R2 zero", {39'd0, zero}, {39'd0, expRes == '0});
    check("R3 overRange", {39'd0, overRange}, {39'd0, expOvr});
    case (sel)
      3'b000: expF = expCarry;
      3'b001: expF = expRes[W-1];
      3'b010: expF = (expRes == '0);
      3'b011: expF = expMain;
      3'b100: expF = $signed(ex) > 0;
      3'b101: expF = $signed(ex) >= 0;
      default: expF = modelFlag;
    endcase
    if (en) modelFlag = expF;
    @(posedge clk);
    #1;
    case (sel)
      3'b000: check("R4 carry/borrow flag", {39'd0, flag}, {39'd0, modelFlag});
      3'b001, 3'b010: check("R5 neg/zero flag", {39'd0, flag}, {39'd0, modelFlag});
      3'b011: check("R6 main overflow flag", {39'd0, flag}, {39'd0, modelFlag});
      3'b100: check("R7 greater-than flag", {39'd0, flag}, {39'd0, modelFlag});
      3'b101: check("R8 greater-or-equal flag", {39'd0, flag}, {39'd0, modelFlag});
      default: check("R9 reserved hold", {39'd0, flag}, {39'd0, modelFlag});
    endcase
    if (!en) check("R10 enable low hold", {39'd0, flag}, {39'd0, modelFlag});
  endtask

  function automatic logic [W-1:0] corner(input int k);
    case (k)
      0:  return 40'h00_00000000;
      1:  return 40'h00_00000001;
      2:  return 40'hFF_FFFFFFFF;
      3:  return 40'h7F_FFFFFFFF;
      4:  return 40'h80_00000000;
      5:  return 40'h00_7FFFFFFF;
      6:  return 40'hFF_80000000;
      7:  return 40'hFF_80000001;
      8:  return 40'h00_80000000;
      9:  return 40'h80_00000001;
      10: return 40'h12_3456789A;
      default: return 40'hC3_A5A55A5A;
    endcase
  endfunction

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset flag", {39'd0, flag}, 40'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R6: the two defining main-field overflow examples
    applyVec(40'hFF_FFFFFFFF, 40'hFF_80000000, 2'b00, 3'b011, 1'b1);
    check("R6 set example", {39'd0, flag}, 40'd1);
    applyVec(40'hFF_FFFFFFFF, 40'hFF_80000001, 2'b00, 3'b011, 1'b1);
    check("R6 clear example", {39'd0, flag}, 40'd0);

    // R7/R8: compares at the +/-2^39 extremes, where the sign of the difference is wrong
    applyVec(40'h7F_FFFFFFFF, 40'h80_00000000, 2'b10, 3'b100, 1'b1);
    check("R7 max>min", {39'd0, flag}, 40'd1);
    applyVec(40'h80_00000000, 40'h7F_FFFFFFFF, 2'b10, 3'b101, 1'b1);
    check("R8 min>=max false", {39'd0, flag}, 40'd0);

    idx = 0;
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        for (int op = 0; op < 3; op++) begin
          for (int s = 0; s < 8; s++) begin
            applyVec(corner(i), corner(j), op[1:0], s[2:0], (idx % 5) != 0);
            idx++;
          end
        end
      end
    end

    // R11: reset again clears a set flag
    applyVec(40'd5, 40'd1, 2'b10, 3'b100, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 async reset", {39'd0, flag}, 40'd0);
    modelFlag = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule